// File: doc/BRIEF.md
# Snapshot-Read 64-bit System Tick Timer

This peripheral keeps a 64-bit free-running tick count behind a small 32-bit register bus. The bus has an address, a write enable, write data and combinational read data. A programmable prescaler paces the count. The count cannot be read word by word. Software first writes a snapshot command, which copies all 64 bits in one clock into a pair of shadow words, and then reads those words at leisure. Both halves always come from the same instant.

Six 32-bit compare channels watch the low word of the count. A channel fires when an advance of the count makes the low word equal to its compare value. A firing channel sets its status flag. An enable mask decides which flags reach the interrupt line, and software clears a flag by writing a 1 to it. The highest channel can also serve as a watchdog: when its arm bit is set, a firing produces a single-cycle reset pulse. Software can preset either half of the count, for example to zero at start-up or to a saved value.

Top module: `tick_timer_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, and `irq` and `wdog_rst` are low.
- R2: Writes to offset 0x00 set the low count word and writes to 0x04 set the high word. A cycle with such a write does not advance the count. Reads of 0x00 and 0x04 return zero.
- R3: Writing a value with bit 0 set to offset 0x30 copies the whole 64-bit count in that cycle. The low half then reads at 0x34 and the high half at 0x38, and both hold their values while the count moves on.
- R4: With divider value D at offset 0x2C, the count advances once every 2*(D+1) clocks. A divider write restarts the pacing, so the first advance lands 2*(D+1) clocks after the write's edge.
- R5: When the low word advances from 0xFFFFFFFF to 0, the high word increments on the same advance.
- R6: Channel n's compare value sits at offset 0x08+4*n, for n = 0 to 5. The channel fires on an advance that makes the low word equal to that value. A preset never fires a channel.
- R7: The status register at 0x20 holds one flag per channel, with bit n belonging to channel n. Writing 1 to a bit clears it, writing 0 leaves it as it is, and a firing in the same cycle wins over the clear.
- R8: `irq` is high exactly while some status bit is set whose bit in the enable register at 0x24 is also set.
- R9: When bit 0 of the register at 0x28 is set and channel 5 fires, `wdog_rst` is high for exactly one clock. With that bit clear, channel 5 only sets its status flag.
- R10: Compare, enable, watchdog-arm and divider registers read back what was written. Offsets 0x30, 0x3C and every other unmapped offset read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Enabled-status interrupt |
| wdog_rst | output | 1 | Single-cycle watchdog reset pulse |

## Verification
The bench builds the block with its defaults: a 16-bit divider and six channels. It runs the divider at 0 and 2, which gives an advance every 2 or 6 clocks, so exact tick counts can be predicted from the cycle of the divider write. It uses a divider of 200 to hold the count still while it sets up presets and compare values. Presets near 0xFFFFFFFF bring the carry into the high word, and presets just below the compare values make channel firings and the watchdog pulse happen within a few dozen clocks.

// File: rtl/tick_timer_pkg.sv
// Shared constants for the tick timer: bus geometry, register offsets and
// channel count. Assumes word-aligned byte offsets on a 6-bit address.
package tick_timer_pkg;
    localparam int REG_AW    = 6;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 64;
    localparam int NUM_CMP   = 6;
    localparam int WDOG_CH   = NUM_CMP - 1;

    localparam logic [REG_AW-1:0] OFS_CNT_LO  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_CNT_HI  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_CMP0    = 6'h08;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 6'h20;
    localparam logic [REG_AW-1:0] OFS_IEN     = 6'h24;
    localparam logic [REG_AW-1:0] OFS_WDEN    = 6'h28;
    localparam logic [REG_AW-1:0] OFS_DIV     = 6'h2C;
    localparam logic [REG_AW-1:0] OFS_SNAPCTL = 6'h30;
    localparam logic [REG_AW-1:0] OFS_SNAP_LO = 6'h34;
    localparam logic [REG_AW-1:0] OFS_SNAP_HI = 6'h38;

    // Byte offset of compare channel idx
    function automatic logic [REG_AW-1:0] cmp_ofs(input int idx);
        return OFS_CMP0 + REG_AW'(idx * 4);
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
// Holds the divider register and paces count advances: one tick every
// 2*(div+1) clocks. A divider write restarts the phase and suppresses the
// tick of that cycle. Assumes DIV_W <= 32.
module tick_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [DIV_W-1:0] div_q,
    output logic             tick
);
    localparam int PRE_W = DIV_W + 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_limit;

    assign pre_limit = {div_q, 1'b1};
    assign tick      = !div_wr && (pre_cnt == pre_limit);

    // Divider register update
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_wr) div_q <= div_wdata;
    end

    // Phase counter: wraps at the limit, restarts on a divider write
    always_ff @(posedge clk) begin
        if (!rst_n)                  pre_cnt <= '0;
        else if (div_wr)             pre_cnt <= '0;
        else if (pre_cnt == pre_limit) pre_cnt <= '0;
        else                         pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tick_counter64.sv
// The 64-bit tick count with word presets and the snapshot pair.
// A preset write in a cycle blocks that cycle's advance. Exposes the
// low word the next advance will produce, for the compare channels.
module tick_counter64
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              snap_wr,
    output logic              adv,
    output logic [WORD_W-1:0] lo_next,
    output logic [CNT_W-1:0]  snap_q
);
    logic [CNT_W-1:0] cnt_q;

    assign adv     = tick && !(lo_wr || hi_wr);
    assign lo_next = cnt_q[WORD_W-1:0] + WORD_W'(1);

    // Count update: presets take priority, otherwise advance on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (lo_wr || hi_wr) begin
            if (lo_wr) cnt_q[WORD_W-1:0]     <= wdata;
            if (hi_wr) cnt_q[CNT_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Snapshot capture of the full count
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (snap_wr) snap_q <= cnt_q;
    end

    // R5
    adv_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !lo_wr && !hi_wr) |=> $stable(cnt_q));
    // R3
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_wr |=> snap_q == $past(cnt_q));
    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_wr |=> $stable(snap_q));
endmodule

// File: rtl/tick_cmp_bank.sv
// Compare channels, status flags (write-one-to-clear, set wins), the
// interrupt enable mask and the watchdog arm bit. Channel WDOG_CH drives
// a one-clock reset pulse when armed. Assumes advances are never in
// consecutive cycles.
module tick_cmp_bank
    import tick_timer_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            adv,
    input  logic [WORD_W-1:0]               lo_next,
    input  logic [NUM_CMP-1:0]              cmp_wr,
    input  logic                            status_wr,
    input  logic                            ien_wr,
    input  logic                            wden_wr,
    input  logic [WORD_W-1:0]               wdata,
    output logic [NUM_CMP-1:0][WORD_W-1:0]  cmp_q,
    output logic [NUM_CMP-1:0]              status_q,
    output logic [NUM_CMP-1:0]              ien_q,
    output logic                            wden_q,
    output logic                            irq,
    output logic                            wdog_rst
);
    logic [NUM_CMP-1:0] fire;
    logic [NUM_CMP-1:0] clr_mask;

    assign clr_mask = status_wr ? wdata[NUM_CMP-1:0] : '0;
    assign irq      = |(status_q & ien_q);

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_ch
        // Compare value register of channel g
        always_ff @(posedge clk) begin
            if (!rst_n)         cmp_q[g] <= '0;
            else if (cmp_wr[g]) cmp_q[g] <= wdata;
        end

        assign fire[g] = adv && (lo_next == cmp_q[g]);

        // R7
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_wr && wdata[g] && !fire[g]) |=> !status_q[g]);
        // R6
        fire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[g] |=> status_q[g]);
    end

    // Status flags: set by firing, cleared by written ones
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | fire;
    end

    // Interrupt enable mask and watchdog arm bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wden_q <= 1'b0;
        end else begin
            if (ien_wr)  ien_q  <= wdata[NUM_CMP-1:0];
            if (wden_wr) wden_q <= wdata[0];
        end
    end

    // Watchdog pulse, one clock after an armed firing
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_rst <= 1'b0;
        else        wdog_rst <= wden_q && fire[WDOG_CH];
    end

    // R9
    wdog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);
    // R9
    wdog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wden_q |=> !wdog_rst);
endmodule

// File: rtl/tick_timer_top.sv
// Top of the tick timer: decodes bus writes into register strobes, wires
// prescaler, count and compare bank, and muxes read data. Reads are
// combinational; writes act on the rising edge. Assumes DIV_W <= 32.
module tick_timer_top
    import tick_timer_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);
    logic                           lo_wr, hi_wr, status_wr, ien_wr;
    logic                           wden_wr, div_wr, snap_wr;
    logic [NUM_CMP-1:0]             cmp_wr;
    logic                           tick, adv;
    logic [WORD_W-1:0]              lo_next;
    logic [CNT_W-1:0]               snap_q;
    logic [DIV_W-1:0]               div_q;
    logic [NUM_CMP-1:0][WORD_W-1:0] cmp_q;
    logic [NUM_CMP-1:0]             status_q, ien_q;
    logic                           wden_q;

    // Write strobe decode
    assign lo_wr     = bus_we && (bus_addr == OFS_CNT_LO);
    assign hi_wr     = bus_we && (bus_addr == OFS_CNT_HI);
    assign status_wr = bus_we && (bus_addr == OFS_STATUS);
    assign ien_wr    = bus_we && (bus_addr == OFS_IEN);
    assign wden_wr   = bus_we && (bus_addr == OFS_WDEN);
    assign div_wr    = bus_we && (bus_addr == OFS_DIV);
    assign snap_wr   = bus_we && (bus_addr == OFS_SNAPCTL) && bus_wdata[0];

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_dec
        assign cmp_wr[g] = bus_we && (bus_addr == cmp_ofs(g));
    end

    tick_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (bus_wdata[DIV_W-1:0]),
        .div_q     (div_q),
        .tick      (tick)
    );

    tick_counter64 u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .wdata   (bus_wdata),
        .snap_wr (snap_wr),
        .adv     (adv),
        .lo_next (lo_next),
        .snap_q  (snap_q)
    );

    tick_cmp_bank u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .lo_next   (lo_next),
        .cmp_wr    (cmp_wr),
        .status_wr (status_wr),
        .ien_wr    (ien_wr),
        .wden_wr   (wden_wr),
        .wdata     (bus_wdata),
        .cmp_q     (cmp_q),
        .status_q  (status_q),
        .ien_q     (ien_q),
        .wden_q    (wden_q),
        .irq       (irq),
        .wdog_rst  (wdog_rst)
    );

    // Read data mux; unmapped and write-only offsets give zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STATUS:  bus_rdata = WORD_W'(status_q);
            OFS_IEN:     bus_rdata = WORD_W'(ien_q);
            OFS_WDEN:    bus_rdata = WORD_W'(wden_q);
            OFS_DIV:     bus_rdata = WORD_W'(div_q);
            OFS_SNAP_LO: bus_rdata = snap_q[WORD_W-1:0];
            OFS_SNAP_HI: bus_rdata = snap_q[CNT_W-1:WORD_W];
            default:     bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_addr == cmp_ofs(i)) bus_rdata = cmp_q[i];
        end
    end

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q & ien_q) != '0);
endmodule

// File: tb/tick_timer_top_bench.sv
`timescale 1ns/1ps
module tick_timer_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdog_rst;

    int n_checks = 0;
    int n_errors = 0;
    int wd_hi = 0;
    bit wd_clear = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t exp_q[$];
    event smp_ev;

    always #2.5 clk = ~clk;

    tick_timer_top u_tick_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdog_rst  (wdog_rst)
    );

    // Count clocks with the watchdog pulse high, sampled mid-cycle
    always @(negedge clk) begin
        if (wd_clear)      wd_hi = 0;
        else if (wdog_rst) wd_hi = wd_hi + 1;
    end

    task automatic check_val(input string tag, input logic [31:0] act,
                             input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected item and compares the sampled read data
    always @(smp_ev) begin
        sb_item_t it;
        it = exp_q.pop_front();
        check_val(it.tag, bus_rdata, it.exp);
    end

    // Driver tasks start and end at a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp,
                      input string tag);
        sb_item_t it;
        bus_addr = a; bus_we = 1'b0;
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        #1 ->smp_ev;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_val("R1 irq", {31'd0, irq}, 32'd0);
        check_val("R1 wdog_rst", {31'd0, wdog_rst}, 32'd0);
        rd(6'h20, 32'd0, "R1 status");
        rd(6'h24, 32'd0, "R1 enable");
        rd(6'h2C, 32'd0, "R1 divider");
        rd(6'h34, 32'd0, "R1 snapshot low");
        rd(6'h08, 32'd0, "R1 compare0");
        // R10 unmapped and control offsets
        rd(6'h3C, 32'd0, "R10 unmapped 0x3C");
        rd(6'h30, 32'd0, "R10 snapshot control");

        // R2/R3 preset and snapshot with the count held
        wr(6'h2C, 32'd200);
        rd(6'h2C, 32'd200, "R10 divider readback");
        wr(6'h00, 32'h1234_5678);
        wr(6'h04, 32'h0000_ABCD);
        rd(6'h00, 32'd0, "R2 count low reads zero");
        rd(6'h04, 32'd0, "R2 count high reads zero");
        wr(6'h30, 32'd1);
        rd(6'h34, 32'h1234_5678, "R3 snapshot low");
        rd(6'h38, 32'h0000_ABCD, "R3 snapshot high");

        // R4 divider 2: 60 clocks to the snapshot give 9 advances
        wr(6'h00, 32'd0);
        wr(6'h04, 32'd0);
        wr(6'h2C, 32'd2);
        idle(59);
        wr(6'h30, 32'd1);
        rd(6'h34, 32'd9, "R4 divider 2 advance count");
        // R3 snapshot stays while counting goes on
        idle(50);
        rd(6'h34, 32'd9, "R3 snapshot held");

        // R4 divider 0: 21 clocks give 10 advances
        wr(6'h2C, 32'd200);
        wr(6'h00, 32'd0);
        wr(6'h04, 32'd0);
        wr(6'h2C, 32'd0);
        idle(20);
        wr(6'h30, 32'd1);
        rd(6'h34, 32'd10, "R4 divider 0 advance count");

        // R5 carry into the high word
        wr(6'h2C, 32'd200);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h04, 32'd5);
        wr(6'h2C, 32'd0);
        idle(3);
        wr(6'h30, 32'd1);
        rd(6'h34, 32'd0, "R5 low after wrap");
        rd(6'h38, 32'd6, "R5 high after wrap");

        // R6 compare firing
        wr(6'h2C, 32'd200);
        wr(6'h08, 32'd103);
        wr(6'h0C, 32'd105);
        wr(6'h10, 32'h0000_DEAD);
        wr(6'h14, 32'd100);
        wr(6'h18, 32'd7);
        wr(6'h1C, 32'd7);
        rd(6'h0C, 32'd105, "R10 compare1 readback");
        wr(6'h00, 32'd100);
        wr(6'h04, 32'd0);
        wr(6'h20, 32'h3F);
        wr(6'h24, 32'd0);
        rd(6'h20, 32'd0, "R7 status cleared before run");
        wr(6'h2C, 32'd0);
        idle(20);
        rd(6'h20, 32'h03, "R6 channels 0 and 1 fired only");
        // R8 masking
        check_val("R8 irq masked", {31'd0, irq}, 32'd0);
        wr(6'h24, 32'h02);
        rd(6'h24, 32'h02, "R10 enable readback");
        check_val("R8 irq enabled", {31'd0, irq}, 32'd1);
        // R7 write-one-to-clear
        wr(6'h20, 32'd0);
        rd(6'h20, 32'h03, "R7 zero write keeps flags");
        wr(6'h20, 32'h01);
        rd(6'h20, 32'h02, "R7 clear bit 0 only");
        check_val("R8 irq still from channel 1", {31'd0, irq}, 32'd1);
        wr(6'h20, 32'h02);
        rd(6'h20, 32'h00, "R7 clear bit 1");
        check_val("R8 irq low after clear", {31'd0, irq}, 32'd0);

        // R9 watchdog disarmed: flag only
        wr(6'h2C, 32'd200);
        wr(6'h1C, 32'd203);
        wr(6'h00, 32'd200);
        wr(6'h20, 32'h3F);
        wr(6'h28, 32'd0);
        wd_clear = 1'b1; @(negedge clk); wd_clear = 1'b0;
        wr(6'h2C, 32'd0);
        idle(20);
        rd(6'h20, 32'h20, "R9 channel 5 flag without arm");
        check_val("R9 no pulse when disarmed", wd_hi, 32'd0);
        check_val("R8 channel 5 masked", {31'd0, irq}, 32'd0);
        wr(6'h24, 32'h20);
        check_val("R8 channel 5 enabled", {31'd0, irq}, 32'd1);

        // R9 watchdog armed: one-clock pulse
        wr(6'h2C, 32'd200);
        wr(6'h20, 32'h3F);
        wr(6'h00, 32'd200);
        wr(6'h28, 32'd1);
        rd(6'h28, 32'd1, "R10 watchdog arm readback");
        wd_clear = 1'b1; @(negedge clk); wd_clear = 1'b0;
        wr(6'h2C, 32'd0);
        idle(20);
        check_val("R9 single-clock pulse", wd_hi, 32'd1);
        rd(6'h20, 32'h20, "R9 channel 5 flag when armed");

        idle(2);
        summary();
    end

    // Run watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end
endmodule